// File: doc/BRIEF.md
# Password Code Security Lock

This block guards a secured memory region with a 128-bit password, kept as eight 16-bit words supplied by non-volatile storage. It decodes a simple word-addressed bus. The bus reaches three things: the secured region, a bank of eight key registers, and a control/status register.

The secured region holds a small scratch store and, above it, the eight read-only password words. While the block is locked, only code fetched from the secured region may touch that region. Debug-port accesses and code running elsewhere are refused.

To unlock, software reads each password word once; these reads are recorded even when they are refused. It then writes the eight key registers with the password. If the stored password is blank (all ones), the completed reads are enough to unlock. Writing the force-lock bit relocks the block and clears the read record. Key and control writes take effect only while a write-protect enable input is high.

Top module: `code_sec_lock`

## Requirements
- R1: After reset `locked_o` is 1, the secured region is refused to non-secure code, and the control register reads 0xFFFF.
- R2: An access that hits the secured region raises `grant_o` when the block is unlocked, or when `secure_fetch_i` is 1 and `debug_i` is 0. While locked, a debug access or an access from code outside the region gets `grant_o` 0. Accesses outside the region never raise `grant_o`.
- R3: A refused read returns 0 on `rdata_o`. A refused write leaves the scratch store unchanged.
- R4: A read of password word i, at region base + RAM_WORDS + i, is recorded whatever its source and in any order. No unlock happens until all eight words have been recorded.
- R5: A key write takes effect only with `prot_wen_i` high. Once all reads are recorded, each such write is judged in the second cycle after it: the block unlocks if all eight keys equal the password and locks otherwise.
- R6: With a password of all ones, `locked_o` falls on the second clock edge after the eighth recorded read, with no key write.
- R7: Key and control writes made while `prot_wen_i` is 0 have no effect.
- R8: A control write with bit 15 set and `prot_wen_i` high locks the block at the next edge. It also clears the read record, so matching key writes do not unlock until the reads are repeated.
- R9: A control register read returns 1 in bits 15..1 and the lock state in bit 0. Key register reads return 0.
- R10: A granted read of a password word returns that word. Password word i is `pwd_i[16*i+15:16*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Word address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DW | Write data |
| secure_fetch_i | input | 1 | Current code runs from the secured region |
| debug_i | input | 1 | Access comes from the debug port |
| prot_wen_i | input | 1 | Write-protect enable for key and control registers |
| pwd_i | input | PW_WORDS*DW | Stored password, word 0 in the low bits |
| rdata_o | output | DW | Read data, combinational, 0 when no read |
| locked_o | output | 1 | 1 while locked |
| grant_o | output | 1 | Secured-region access allowed this cycle |

## Verification
The assertions assume that `rd_i` and `wr_i` are never high together. They also assume that `pwd_i` stays still between resets, since the blank test and the key comparison read it directly. The stimulus raises at most one strobe per cycle, and changes the password only while reset is held.

// File: rtl/code_sec_lock_pkg.sv
package code_sec_lock_pkg;
  typedef enum logic [2:0] {
    HIT_NONE,
    HIT_RAM,
    HIT_PWD,
    HIT_KEY,
    HIT_CTRL
  } hit_e;
endpackage

// File: rtl/csl_decode.sv
module csl_decode
  import code_sec_lock_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW_WORDS = 8,
  parameter int RAM_WORDS = 8,
  parameter int IDXW = 3,
  parameter logic [AW-1:0] SEC_BASE = 16'h0100,
  parameter logic [AW-1:0] KEY_BASE = 16'h0040
) (
  input  logic [AW-1:0]   addr_i,
  output hit_e            hit_o,
  output logic [IDXW-1:0] idx_o
);
  localparam logic [AW-1:0] RAM_N  = AW'(RAM_WORDS);
  localparam logic [AW-1:0] PW_N   = AW'(PW_WORDS);
  localparam logic [AW-1:0] SEC_N  = AW'(RAM_WORDS + PW_WORDS);
  localparam logic [AW-1:0] CTRL_A = KEY_BASE + PW_N;

  logic [AW-1:0] off_s, off_p, off_k;

  always_comb begin
    off_s = addr_i - SEC_BASE;
    off_p = off_s - RAM_N;
    off_k = addr_i - KEY_BASE;
    hit_o = HIT_NONE;
    idx_o = '0;
    if (addr_i >= SEC_BASE && off_s < RAM_N) begin
      hit_o = HIT_RAM;
      idx_o = off_s[IDXW-1:0];
    end else if (addr_i >= SEC_BASE && off_s < SEC_N) begin
      hit_o = HIT_PWD;
      idx_o = off_p[IDXW-1:0];
    end else if (addr_i >= KEY_BASE && off_k < PW_N) begin
      hit_o = HIT_KEY;
      idx_o = off_k[IDXW-1:0];
    end else if (addr_i == CTRL_A) begin
      hit_o = HIT_CTRL;
    end
  end
endmodule

// File: rtl/csl_keys.sv
module csl_keys #(
  parameter int DW = 16,
  parameter int PW_WORDS = 8,
  parameter int IDXW = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic                   sel_i,
  input  logic                   prot_i,
  input  logic [IDXW-1:0]        idx_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [PW_WORDS*DW-1:0] pwd_i,
  output logic                   match_o,
  output logic                   wr_pend_o
);
  localparam int KW = PW_WORDS * DW;

  logic [KW-1:0] key_q;
  logic          we;

  assign we = wr_i & sel_i & prot_i;

  for (genvar w = 0; w < PW_WORDS; w++) begin : g_key
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            key_q[w*DW +: DW] <= '1;
      else if (we && idx_i == IDXW'(w))       key_q[w*DW +: DW] <= wdata_i;
    end
  end

  // comparison is sampled one cycle after the write lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_pend_o <= 1'b0;
    else         wr_pend_o <= we;
  end

  assign match_o = (key_q == pwd_i);

  assert_key_wp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i && !prot_i) |=> $stable(key_q));
  assert_key_pend_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i && prot_i) |=> wr_pend_o);
endmodule

// File: rtl/csl_tracker.sv
module csl_tracker #(
  parameter int PW_WORDS = 8,
  parameter int IDXW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic            clr_i,
  output logic            full_o
);
  logic [PW_WORDS-1:0] seen_q;

  for (genvar w = 0; w < PW_WORDS; w++) begin : g_seen
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               seen_q[w] <= 1'b0;
      else if (clr_i)                            seen_q[w] <= 1'b0;
      else if (set_i && idx_i == IDXW'(w))       seen_q[w] <= 1'b1;
    end
  end

  assign full_o = &seen_q;

  assert_trk_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (seen_q == '0));
  assert_trk_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ($countones(seen_q) <= $countones($past(seen_q)) + 1));
endmodule

// File: rtl/csl_sram.sv
module csl_sram #(
  parameter int DW = 16,
  parameter int RAM_WORDS = 8,
  parameter int IDXW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o
);
  logic [RAM_WORDS*DW-1:0] mem_q;

  for (genvar w = 0; w < RAM_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[w*DW +: DW] <= '0;
      else if (we_i && idx_i == IDXW'(w))   mem_q[w*DW +: DW] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i*DW +: DW];

  assert_ram_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q));
endmodule

// File: rtl/code_sec_lock.sv
module code_sec_lock
  import code_sec_lock_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int PW_WORDS = 8,
  parameter int RAM_WORDS = 8,
  parameter logic [AW-1:0] SEC_BASE = 16'h0100,
  parameter logic [AW-1:0] KEY_BASE = 16'h0040,
  parameter int FORCE_BIT = 15
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [AW-1:0]          addr_i,
  input  logic                   rd_i,
  input  logic                   wr_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic                   secure_fetch_i,
  input  logic                   debug_i,
  input  logic                   prot_wen_i,
  input  logic [PW_WORDS*DW-1:0] pwd_i,
  output logic [DW-1:0]          rdata_o,
  output logic                   locked_o,
  output logic                   grant_o
);
  localparam int IDXW = ($clog2(PW_WORDS) > $clog2(RAM_WORDS)) ?
                        $clog2(PW_WORDS) : $clog2(RAM_WORDS);

  hit_e            hit;
  logic [IDXW-1:0] idx;
  logic            in_sec, allow;
  logic            ram_we, ctrl_wr, force_lock, trk_set, trk_full;
  logic            key_match, key_pend, blank;
  logic [DW-1:0]   ram_rd;
  logic            locked_q;

  csl_decode #(
    .AW(AW), .PW_WORDS(PW_WORDS), .RAM_WORDS(RAM_WORDS), .IDXW(IDXW),
    .SEC_BASE(SEC_BASE), .KEY_BASE(KEY_BASE)
  ) u_decode (
    .addr_i(addr_i), .hit_o(hit), .idx_o(idx)
  );

  assign in_sec  = (hit == HIT_RAM) || (hit == HIT_PWD);
  assign allow   = !locked_q || (secure_fetch_i && !debug_i);
  assign grant_o = (rd_i || wr_i) && in_sec && allow;

  assign ram_we     = wr_i && (hit == HIT_RAM) && grant_o;
  assign ctrl_wr    = wr_i && (hit == HIT_CTRL) && prot_wen_i;
  assign force_lock = ctrl_wr && wdata_i[FORCE_BIT];
  assign trk_set    = rd_i && (hit == HIT_PWD);
  assign blank      = &pwd_i;

  csl_sram #(.DW(DW), .RAM_WORDS(RAM_WORDS), .IDXW(IDXW)) u_sram (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(ram_we), .idx_i(idx),
    .wdata_i(wdata_i), .rdata_o(ram_rd)
  );

  csl_tracker #(.PW_WORDS(PW_WORDS), .IDXW(IDXW)) u_tracker (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(trk_set), .idx_i(idx),
    .clr_i(force_lock), .full_o(trk_full)
  );

  csl_keys #(.DW(DW), .PW_WORDS(PW_WORDS), .IDXW(IDXW)) u_keys (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .sel_i(hit == HIT_KEY),
    .prot_i(prot_wen_i), .idx_i(idx), .wdata_i(wdata_i), .pwd_i(pwd_i),
    .match_o(key_match), .wr_pend_o(key_pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  locked_q <= 1'b1;
    else if (force_lock)          locked_q <= 1'b1;
    else if (key_pend && trk_full) locked_q <= !(blank || key_match);
    else if (trk_full && blank)   locked_q <= 1'b0;
  end

  assign locked_o = locked_q;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (hit)
        HIT_RAM:  if (grant_o) rdata_o = ram_rd;
        HIT_PWD:  if (grant_o) rdata_o = pwd_i[idx*DW +: DW];
        HIT_CTRL: rdata_o = {{(DW-1){1'b1}}, locked_q};
        default:  rdata_o = '0;
      endcase
    end
  end

  assert_refused_rd_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && in_sec && !grant_o) |-> (rdata_o == '0));
  assert_unlock_after_reads_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> $past(trk_full));
  assert_force_relock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit == HIT_CTRL && prot_wen_i && wdata_i[FORCE_BIT]) |=> locked_o);
  assert_debug_refused_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (debug_i && locked_o) |-> !grant_o);
  assert_no_grant_outside_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit == HIT_KEY || hit == HIT_CTRL || hit == HIT_NONE) |-> !grant_o);
endmodule

// File: tb/code_sec_lock_tb.sv
`timescale 1ns/1ps
module code_sec_lock_tb;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_ID = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [15:0] data;
    logic        sec;
    logic        dbg;
    logic        prot;
    logic [15:0] e_rd;
    logic        e_lk;
    logic        e_gr;
    logic [3:0]  req;
  } vec_t;

  // pw word i = C3A0+i; RAM at 0100, pw at 0108, keys at 0040, ctrl at 0048
  localparam int NV = 42;
  localparam vec_t VEC [NV] = '{
    '{OP_RD, 16'h0100, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd3},  // R3
    '{OP_WR, 16'h0100, 16'h5678, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 4'd2},  // R2
    '{OP_WR, 16'h0100, 16'h1234, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd3},
    '{OP_RD, 16'h0100, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h5678, 1'b1, 1'b1, 4'd3},
    '{OP_RD, 16'h0100, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd2},
    '{OP_RD, 16'h0108, 16'h0000, 1'b1, 1'b0, 1'b0, 16'hC3A0, 1'b1, 1'b1, 4'd10}, // R10
    '{OP_RD, 16'h0109, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd4},  // R4
    '{OP_RD, 16'h010A, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd4},
    '{OP_RD, 16'h010B, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd4},
    '{OP_RD, 16'h010C, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd4},
    '{OP_RD, 16'h010D, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd4},
    '{OP_RD, 16'h010E, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd4},
    '{OP_RD, 16'h010F, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd4},
    '{OP_RD, 16'h0108, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd4},
    '{OP_WR, 16'h0040, 16'hC3A0, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 4'd5},  // R5
    '{OP_WR, 16'h0041, 16'hC3A1, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 4'd5},
    '{OP_WR, 16'h0042, 16'hC3A2, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 4'd5},
    '{OP_WR, 16'h0043, 16'hC3A3, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 4'd5},
    '{OP_WR, 16'h0044, 16'hC3A4, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 4'd5},
    '{OP_WR, 16'h0045, 16'hC3A5, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 4'd5},
    '{OP_WR, 16'h0046, 16'hC3A6, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 4'd5},
    '{OP_WR, 16'h0047, 16'hC3A7, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 4'd5},
    '{OP_ID, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd5},
    '{OP_RD, 16'h0100, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h5678, 1'b0, 1'b1, 4'd2},
    '{OP_RD, 16'h010B, 16'h0000, 1'b0, 1'b0, 1'b0, 16'hC3A3, 1'b0, 1'b1, 4'd10},
    '{OP_WR, 16'h0043, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd7},  // R7
    '{OP_ID, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd7},
    '{OP_RD, 16'h0048, 16'h0000, 1'b0, 1'b0, 1'b0, 16'hFFFE, 1'b0, 1'b0, 4'd9},  // R9
    '{OP_RD, 16'h0042, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd9},
    '{OP_WR, 16'h0043, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 4'd5},
    '{OP_ID, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd5},
    '{OP_RD, 16'h0048, 16'h0000, 1'b0, 1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b0, 4'd5},
    '{OP_WR, 16'h0043, 16'hC3A3, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 4'd5},
    '{OP_ID, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd5},
    '{OP_RD, 16'h0100, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h5678, 1'b0, 1'b1, 4'd5},
    '{OP_WR, 16'h0048, 16'h8000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd7},
    '{OP_RD, 16'h0048, 16'h0000, 1'b0, 1'b0, 1'b0, 16'hFFFE, 1'b0, 1'b0, 4'd7},
    '{OP_WR, 16'h0048, 16'h8000, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 4'd8},  // R8
    '{OP_RD, 16'h0048, 16'h0000, 1'b0, 1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b0, 4'd8},
    '{OP_WR, 16'h0040, 16'hC3A0, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 4'd8},
    '{OP_ID, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd8},
    '{OP_RD, 16'h0100, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd8}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  addr = '0;
  logic         rd = 1'b0, wr = 1'b0;
  logic [15:0]  wdata = '0;
  logic         sec = 1'b0, dbg = 1'b0, prot = 1'b0;
  logic [127:0] pwd;
  logic [15:0]  rdata;
  logic         locked, grant;
  int           checks = 0;
  int           fails = 0;

  always #2.5 clk = ~clk;

  code_sec_lock u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .secure_fetch_i(sec), .debug_i(dbg), .prot_wen_i(prot),
    .pwd_i(pwd), .rdata_o(rdata), .locked_o(locked), .grant_o(grant)
  );

  task automatic set_pw(input logic [15:0] base, input logic inc);
    for (int i = 0; i < 8; i++) pwd[16*i +: 16] = inc ? base + 16'(i) : base;
  endtask

  task automatic chk(input logic ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, settle 1 ns; comb outputs valid before the next posedge
  task automatic step(input logic [1:0] op, input logic [15:0] a, input logic [15:0] d,
                      input logic s, input logic g, input logic p);
    @(negedge clk);
    rd = (op == OP_RD); wr = (op == OP_WR);
    addr = a; wdata = d; sec = s; dbg = g; prot = p;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rd = 1'b0; wr = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired, R1 sequence incomplete");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    set_pw(16'hC3A0, 1'b1);
    do_reset();

    // R1 reset state
    step(OP_RD, 16'h0048, 16'h0, 1'b0, 1'b0, 1'b0);
    chk(locked === 1'b1, "R1 locked after reset", 16'(locked), 16'h1);
    chk(rdata === 16'hFFFF, "R1 ctrl reset value", rdata, 16'hFFFF);
    step(OP_RD, 16'h0101, 16'h0, 1'b0, 1'b0, 1'b0);
    chk(grant === 1'b0, "R1 region refused after reset", 16'(grant), 16'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].op, VEC[i].addr, VEC[i].data, VEC[i].sec, VEC[i].dbg, VEC[i].prot);
      chk(rdata === VEC[i].e_rd, $sformatf("R%0d vec%0d rdata", VEC[i].req, i),
          rdata, VEC[i].e_rd);
      chk(locked === VEC[i].e_lk, $sformatf("R%0d vec%0d locked", VEC[i].req, i),
          16'(locked), 16'(VEC[i].e_lk));
      chk(grant === VEC[i].e_gr, $sformatf("R%0d vec%0d grant", VEC[i].req, i),
          16'(grant), 16'(VEC[i].e_gr));
    end

    // R4: seven reads in reverse order, correct keys, must stay locked
    do_reset();
    for (int i = 6; i >= 0; i--) step(OP_RD, 16'h0108 + 16'(i), 16'h0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) step(OP_WR, 16'h0040 + 16'(i), 16'hC3A0 + 16'(i), 1'b0, 1'b0, 1'b1);
    step(OP_ID, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    step(OP_ID, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    chk(locked === 1'b1, "R4 partial reads keep lock", 16'(locked), 16'h1);
    step(OP_RD, 16'h010F, 16'h0, 1'b0, 1'b1, 1'b0);
    step(OP_WR, 16'h0040, 16'hC3A0, 1'b0, 1'b0, 1'b1);
    step(OP_ID, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    step(OP_ID, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    chk(locked === 1'b0, "R4 last read then key write unlocks", 16'(locked), 16'h0);

    // R6: blank password unlocks on reads alone
    @(negedge clk); rst_n = 1'b0; set_pw(16'hFFFF, 1'b0);
    do_reset();
    for (int i = 0; i < 7; i++) step(OP_RD, 16'h0108 + 16'(i), 16'h0, 1'b0, 1'b0, 1'b0);
    step(OP_ID, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    step(OP_ID, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    chk(locked === 1'b1, "R6 blank but reads incomplete", 16'(locked), 16'h1);
    step(OP_RD, 16'h010F, 16'h0, 1'b0, 1'b0, 1'b0);
    step(OP_ID, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    chk(locked === 1'b1, "R6 one edge after last read", 16'(locked), 16'h1);
    step(OP_RD, 16'h0102, 16'h0, 1'b0, 1'b0, 1'b0);
    chk(locked === 1'b0, "R6 blank unlocked", 16'(locked), 16'h0);
    chk(grant === 1'b1, "R6 R2 access granted when unlocked", 16'(grant), 16'h1);

    @(negedge clk); rd = 1'b0; wr = 1'b0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule